// File: doc/BRIEF.md
# Trap entry sequencer

This block performs the architectural state update that a 64-bit processor with register windows needs when it takes a trap. The surrounding core presents a one-cycle trap request with a 9-bit trap type. In the same cycle it presents the current program counter and next program counter, condition codes, address space identifier, processor state word, window pointer, save count, global level and trap level, the two trap base registers and a hypervisor-mode flag.

In one clock edge the block raises the trap level and applies saturation into a red (recovery) state. It stores a trap-state record (packed state word, PC, NPC, trap type) into a small per-level array. It chooses the new privilege and global-set bits from the trap type, moves the window pointer for window traps, and forms the vector address and its successor. A trap that arrives when the level is already at the ceiling latches an error state instead. The stored records are read back through a registered read port, so the array can map onto block RAM.

Top module: `trap_entry_unit`

## Requirements
- R1: A request with current level at or above MAXTL (default 6) does the following. It sets `err_o`, which stays set until reset. It leaves `done_o` low. It changes no state output and writes no array entry. Every later request is ignored in the same way until reset.
- R2: For an accepted request, `new_tl_o` is the current level plus one. PSTATE bit 5 (red state) is set only when the current level equals MAXTL-1, and is clear otherwise.
- R3: The saved state word is laid out as follows. The window pointer sits at bits 2:0. The current PSTATE ANDed with 0xF3F sits at bits 19:8. The address space identifier sits at bits 31:24 and the condition codes at bits 39:32. All other bits are zero, except the global field of R5.
- R4: The record is written to the array entry indexed by the new trap level. It can be read on `rd_*` one clock after `rd_lvl_i` is presented, and holds the state word, the current PC, the current NPC and the trap type.
- R5: With the global-level option on (default), `new_gl_o` is the current global level plus one, modulo 8. The current global level is stored at state-word bits 42:40.
- R6: The new PSTATE is bit 4 (FP enable) and bit 2 (privileged), plus exactly one global-set bit. Bit 11 is set for trap type 0x060. Bit 10 is set for types 0x008, 0x030 and 0x064 to 0x06F. Bit 0 is set for every other type. All other bits are zero apart from bit 5 (R2).
- R7: With NWIN windows (default 8), the window pointer changes by trap type. Type 0x024 gives CWP-1. A type whose bits 8:6 equal 010 gives CWP-CANSAVE-2. A type whose bits 8:6 equal 011 gives CWP+1. Any other type leaves CWP unchanged. All of this is modulo NWIN.
- R8: With `hyper_i` high, `new_pc_o` is `htba_i` with bits 13:0 cleared, ORed with the trap type shifted left by 5.
- R9: With `hyper_i` low, `new_pc_o` is `tba_i` with bits 14:0 cleared, with bit 14 set when the new level is above 1, ORed with the trap type shifted left by 5.
- R10: `new_npc_o` equals `new_pc_o` plus 4. `done_o` is high exactly in the cycle after an accepted request. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req_i | input | 1 | Trap request, one cycle |
| trap_type_i | input | 9 | Trap type |
| cur_pc_i | input | ADDR_W | Current PC |
| cur_npc_i | input | ADDR_W | Current NPC |
| cur_ccr_i | input | 8 | Condition codes |
| cur_asi_i | input | 8 | Address space identifier |
| cur_pstate_i | input | 12 | Current processor state word |
| cur_cwp_i | input | CWP_W | Current window pointer |
| cur_cansave_i | input | CWP_W | Current save count |
| cur_gl_i | input | 3 | Current global level |
| cur_tl_i | input | LVL_W | Current trap level |
| tba_i | input | ADDR_W | Trap base |
| htba_i | input | ADDR_W | Hypervisor trap base |
| hyper_i | input | 1 | Hypervisor mode |
| rd_lvl_i | input | LVL_W | Record read index |
| done_o | output | 1 | Trap committed strobe |
| err_o | output | 1 | Sticky error state |
| new_tl_o | output | LVL_W | New trap level |
| new_pstate_o | output | 12 | New processor state word |
| new_cwp_o | output | CWP_W | New window pointer |
| new_gl_o | output | 3 | New global level |
| new_pc_o | output | ADDR_W | Vector address |
| new_npc_o | output | ADDR_W | Vector address plus 4 |
| rd_tstate_o | output | 64 | Stored state word |
| rd_tpc_o | output | ADDR_W | Stored PC |
| rd_tnpc_o | output | ADDR_W | Stored NPC |
| rd_tt_o | output | 9 | Stored trap type |

## Verification
The hardest situations to reach are the ones at the level ceiling. These are a trap taken at MAXTL-1, which must both set red state and still raise the level, and a trap at or above MAXTL, which must freeze everything. In a core these need a deep chain of nested traps. Here the current level is an input, so the bench sweeps every legal level against all 512 trap types and then drives levels 6 and 7 directly. After each trap it reads the freshly written record back through the read port. This checks both the entry index and the packed fields.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int TT_W = 9;
  localparam int PST_W = 12;

  // processor state word bit positions (the 0xF3F save mask depends on them)
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;

  localparam logic [PST_W-1:0] PST_SAVE_MASK = 12'hF3F;

  // trap type codes the sequencer decodes
  localparam logic [TT_W-1:0] TT_INSTR_FAULT = 9'h008;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN   = 9'h024;
  localparam logic [TT_W-1:0] TT_DATA_FAULT  = 9'h030;
  localparam logic [TT_W-1:0] TT_INT_VECTOR  = 9'h060;
  localparam logic [TT_W-1:0] TT_MMU_LO      = 9'h064;
  localparam logic [TT_W-1:0] TT_MMU_HI      = 9'h06F;
  localparam logic [TT_W-1:0] TT_GROUP_MASK  = 9'h1C0;
  localparam logic [TT_W-1:0] TT_SPILL_GRP   = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL_GRP    = 9'h0C0;

  typedef enum logic [1:0] {
    WIN_KEEP  = 2'd0,
    WIN_CLEAN = 2'd1,
    WIN_SPILL = 2'd2,
    WIN_FILL  = 2'd3
  } win_op_e;

  typedef enum logic [1:0] {
    GSET_ALT = 2'd0,
    GSET_MMU = 2'd1,
    GSET_INT = 2'd2
  } gset_e;

endpackage

// File: rtl/trap_class_decode.sv
module trap_class_decode
  import trap_pkg::*;
(
  input  logic [TT_W-1:0] tt_i,
  output gset_e           gset_o,
  output win_op_e         win_o
);

  logic [TT_W-1:0] grp;

  always_comb begin
    grp = tt_i & TT_GROUP_MASK;

    if (tt_i == TT_INT_VECTOR) begin
      gset_o = GSET_INT;
    end else if (tt_i == TT_INSTR_FAULT || tt_i == TT_DATA_FAULT ||
                 (tt_i >= TT_MMU_LO && tt_i <= TT_MMU_HI)) begin
      gset_o = GSET_MMU;
    end else begin
      gset_o = GSET_ALT;
    end

    if (tt_i == TT_CLEAN_WIN) begin
      win_o = WIN_CLEAN;
    end else if (grp == TT_SPILL_GRP) begin
      win_o = WIN_SPILL;
    end else if (grp == TT_FILL_GRP) begin
      win_o = WIN_FILL;
    end else begin
      win_o = WIN_KEEP;
    end
  end

endmodule

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl #(
  parameter int MAXTL = 6,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] cur_tl_i,
  output logic             fault_o,
  output logic             red_o,
  output logic [LVL_W-1:0] new_tl_o
);

  always_comb begin
    fault_o  = (cur_tl_i >= LVL_W'(MAXTL));
    red_o    = !(cur_tl_i < LVL_W'(MAXTL - 1));
    new_tl_o = cur_tl_i + LVL_W'(1);
  end

endmodule

// File: rtl/trap_window_calc.sv
module trap_window_calc
  import trap_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int CWP_W = 3
) (
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [CWP_W-1:0] cansave_i,
  input  win_op_e          op_i,
  output logic [CWP_W-1:0] cwp_o
);

  int acc;

  always_comb begin
    unique case (op_i)
      WIN_CLEAN: acc = int'(cwp_i) + NWIN - 1;
      WIN_SPILL: acc = int'(cwp_i) + 2 * NWIN - int'(cansave_i) - 2;
      WIN_FILL:  acc = int'(cwp_i) + 1;
      default:   acc = int'(cwp_i);
    endcase
    cwp_o = CWP_W'(acc % NWIN);
  end

endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] tba_i,
  input  logic [ADDR_W-1:0] htba_i,
  input  logic              hyper_i,
  input  logic              nested_i,
  input  logic [TT_W-1:0]   tt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] npc_o
);

  localparam logic [ADDR_W-1:0] HYP_KEEP = ~ADDR_W'(15'h3FFF);
  localparam logic [ADDR_W-1:0] SUP_KEEP = ~ADDR_W'(15'h7FFF);
  localparam logic [ADDR_W-1:0] NEST_BIT = ADDR_W'(1) << 14;

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;

  always_comb begin
    offset = ADDR_W'(tt_i) << 5;
    if (hyper_i) begin
      base = htba_i & HYP_KEEP;
    end else begin
      base = (tba_i & SUP_KEEP) | (nested_i ? NEST_BIT : '0);
    end
    pc_o  = base | offset;
    npc_o = pc_o + ADDR_W'(4);
  end

endmodule

// File: rtl/trap_state_ram.sv
module trap_state_ram #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3,
  parameter int DW    = 201
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= mem[raddr_i];
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int MAXTL  = 6,
  parameter int NWIN   = 8,
  parameter int ADDR_W = 64,
  parameter int HAS_GL = 1,
  localparam int LVL_W = $clog2(MAXTL + 1),
  localparam int CWP_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req_i,
  input  logic [8:0]        trap_type_i,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] cur_npc_i,
  input  logic [7:0]        cur_ccr_i,
  input  logic [7:0]        cur_asi_i,
  input  logic [11:0]       cur_pstate_i,
  input  logic [CWP_W-1:0]  cur_cwp_i,
  input  logic [CWP_W-1:0]  cur_cansave_i,
  input  logic [2:0]        cur_gl_i,
  input  logic [LVL_W-1:0]  cur_tl_i,
  input  logic [ADDR_W-1:0] tba_i,
  input  logic [ADDR_W-1:0] htba_i,
  input  logic              hyper_i,
  input  logic [LVL_W-1:0]  rd_lvl_i,
  output logic              done_o,
  output logic              err_o,
  output logic [LVL_W-1:0]  new_tl_o,
  output logic [11:0]       new_pstate_o,
  output logic [CWP_W-1:0]  new_cwp_o,
  output logic [2:0]        new_gl_o,
  output logic [ADDR_W-1:0] new_pc_o,
  output logic [ADDR_W-1:0] new_npc_o,
  output logic [63:0]       rd_tstate_o,
  output logic [ADDR_W-1:0] rd_tpc_o,
  output logic [ADDR_W-1:0] rd_tnpc_o,
  output logic [8:0]        rd_tt_o
);

  localparam int DEPTH = 1 << LVL_W;
  localparam int REC_W = 64 + 2 * ADDR_W + TT_W;

  // decoded trap class
  gset_e   gset;
  win_op_e win_op;

  // level control
  logic             lvl_fault;
  logic             red_next;
  logic [LVL_W-1:0] tl_next;

  // next-state values
  logic [CWP_W-1:0]  cwp_next;
  logic [ADDR_W-1:0] pc_next;
  logic [ADDR_W-1:0] npc_next;
  logic [PST_W-1:0]  pst_next;
  logic [2:0]        gl_next;
  logic [2:0]        gl_saved;
  logic [63:0]       tstate_word;
  logic              accept;
  logic              fault_hit;

  // registered state
  logic              done_q;
  logic              err_q;
  logic [LVL_W-1:0]  tl_q;
  logic [PST_W-1:0]  pst_q;
  logic [CWP_W-1:0]  cwp_q;
  logic [2:0]        gl_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] npc_q;
  logic [REC_W-1:0]  rec_rd;

  trap_class_decode u_decode (
    .tt_i   (trap_type_i),
    .gset_o (gset),
    .win_o  (win_op)
  );

  trap_level_ctrl #(
    .MAXTL (MAXTL),
    .LVL_W (LVL_W)
  ) u_level (
    .cur_tl_i (cur_tl_i),
    .fault_o  (lvl_fault),
    .red_o    (red_next),
    .new_tl_o (tl_next)
  );

  trap_window_calc #(
    .NWIN  (NWIN),
    .CWP_W (CWP_W)
  ) u_window (
    .cwp_i     (cur_cwp_i),
    .cansave_i (cur_cansave_i),
    .op_i      (win_op),
    .cwp_o     (cwp_next)
  );

  trap_vector_gen #(
    .ADDR_W (ADDR_W)
  ) u_vector (
    .tba_i    (tba_i),
    .htba_i   (htba_i),
    .hyper_i  (hyper_i),
    .nested_i (tl_next > LVL_W'(1)),
    .tt_i     (trap_type_i),
    .pc_o     (pc_next),
    .npc_o    (npc_next)
  );

  // global-level option picks the stepping and the saved field
  if (HAS_GL != 0) begin : g_gl
    assign gl_next  = cur_gl_i + 3'd1;
    assign gl_saved = cur_gl_i;
  end else begin : g_no_gl
    assign gl_next  = cur_gl_i;
    assign gl_saved = 3'd0;
  end

  always_comb begin
    pst_next = '0;
    pst_next[PS_PEF]  = 1'b1;
    pst_next[PS_PRIV] = 1'b1;
    pst_next[PS_RED]  = red_next;
    unique case (gset)
      GSET_INT: pst_next[PS_IG] = 1'b1;
      GSET_MMU: pst_next[PS_MG] = 1'b1;
      default:  pst_next[PS_AG] = 1'b1;
    endcase
  end

  always_comb begin
    tstate_word = '0;
    tstate_word[CWP_W-1:0] = cur_cwp_i;
    tstate_word[19:8]      = cur_pstate_i & PST_SAVE_MASK;
    tstate_word[31:24]     = cur_asi_i;
    tstate_word[39:32]     = cur_ccr_i;
    tstate_word[42:40]     = gl_saved;
  end

  assign accept    = trap_req_i && !err_q && !lvl_fault;
  assign fault_hit = trap_req_i && !err_q && lvl_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      tl_q   <= '0;
      pst_q  <= '0;
      cwp_q  <= '0;
      gl_q   <= '0;
      pc_q   <= '0;
      npc_q  <= '0;
    end else begin
      done_q <= accept;
      if (fault_hit) begin
        err_q <= 1'b1;
      end
      if (accept) begin
        tl_q  <= tl_next;
        pst_q <= pst_next;
        cwp_q <= cwp_next;
        gl_q  <= gl_next;
        pc_q  <= pc_next;
        npc_q <= npc_next;
      end
    end
  end

  trap_state_ram #(
    .DEPTH (DEPTH),
    .IDX_W (LVL_W),
    .DW    (REC_W)
  ) u_records (
    .clk     (clk),
    .rst     (rst),
    .we_i    (accept),
    .waddr_i (tl_next),
    .wdata_i ({tstate_word, cur_pc_i, cur_npc_i, trap_type_i}),
    .raddr_i (rd_lvl_i),
    .rdata_o (rec_rd)
  );

  assign done_o       = done_q;
  assign err_o        = err_q;
  assign new_tl_o     = tl_q;
  assign new_pstate_o = pst_q;
  assign new_cwp_o    = cwp_q;
  assign new_gl_o     = gl_q;
  assign new_pc_o     = pc_q;
  assign new_npc_o    = npc_q;
  assign rd_tstate_o  = rec_rd[REC_W-1 -: 64];
  assign rd_tpc_o     = rec_rd[TT_W + 2*ADDR_W - 1 -: ADDR_W];
  assign rd_tnpc_o    = rec_rd[TT_W + ADDR_W - 1 -: ADDR_W];
  assign rd_tt_o      = rec_rd[TT_W-1:0];

  // R1: error state is sticky and blocks commits
  p_err_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  p_err_no_done_r1: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !done_q);
  // R2: committed level in range, red exactly at the ceiling
  p_tl_range_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (tl_q >= LVL_W'(1) && tl_q <= LVL_W'(MAXTL)));
  p_red_ceiling_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (pst_q[PS_RED] == (tl_q == LVL_W'(MAXTL))));
  // R6: exactly one global set selected
  p_one_gset_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($countones({pst_q[PS_AG], pst_q[PS_MG], pst_q[PS_IG]}) == 1));
  // R8: vector is 32-byte aligned
  p_vec_align_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (pc_q[4:0] == 5'd0));
  // R10: successor address follows vector
  p_npc_step_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (npc_q == pc_q + ADDR_W'(4)));
  // R10: no commit without a request one cycle earlier
  p_done_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
    !trap_req_i |=> !done_q);

endmodule

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;

  localparam int MAXTL  = 6;
  localparam int NWIN   = 8;
  localparam int ADDR_W = 64;
  localparam int LVL_W  = 3;
  localparam int CWP_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trap_req = 1'b0;
  logic [8:0]        trap_type = '0;
  logic [ADDR_W-1:0] cur_pc = '0, cur_npc = '0, tba = '0, htba = '0;
  logic [7:0]        ccr = '0, asi = '0;
  logic [11:0]       pstate = '0;
  logic [CWP_W-1:0]  cwp = '0, cansave = '0;
  logic [2:0]        gl = '0;
  logic [LVL_W-1:0]  tl = '0, rd_lvl = '0;
  logic              hyper = 1'b0;

  logic              done, err;
  logic [LVL_W-1:0]  new_tl;
  logic [11:0]       new_pstate;
  logic [CWP_W-1:0]  new_cwp;
  logic [2:0]        new_gl;
  logic [ADDR_W-1:0] new_pc, new_npc, rd_tpc, rd_tnpc;
  logic [63:0]       rd_tstate;
  logic [8:0]        rd_tt;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  trap_entry_unit #(.MAXTL(MAXTL), .NWIN(NWIN), .ADDR_W(ADDR_W), .HAS_GL(1)) dut (
    .clk(clk), .rst(rst), .trap_req_i(trap_req), .trap_type_i(trap_type),
    .cur_pc_i(cur_pc), .cur_npc_i(cur_npc), .cur_ccr_i(ccr), .cur_asi_i(asi),
    .cur_pstate_i(pstate), .cur_cwp_i(cwp), .cur_cansave_i(cansave),
    .cur_gl_i(gl), .cur_tl_i(tl), .tba_i(tba), .htba_i(htba), .hyper_i(hyper),
    .rd_lvl_i(rd_lvl), .done_o(done), .err_o(err), .new_tl_o(new_tl),
    .new_pstate_o(new_pstate), .new_cwp_o(new_cwp), .new_gl_o(new_gl),
    .new_pc_o(new_pc), .new_npc_o(new_npc), .rd_tstate_o(rd_tstate),
    .rd_tpc_o(rd_tpc), .rd_tnpc_o(rd_tnpc), .rd_tt_o(rd_tt)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_inputs(input int t_lvl, input int t_tt);
    trap_type = 9'(t_tt);
    tl        = LVL_W'(t_lvl);
    cur_pc    = 64'h0000_4000_0000_1000 + 64'(t_tt * 16) + 64'(t_lvl << 24);
    cur_npc   = cur_pc + 64'd4;
    ccr       = 8'(t_tt) ^ 8'h3C;
    asi       = ~8'(t_tt + t_lvl);
    pstate    = 12'(t_tt * 7) ^ 12'hA5A;
    cwp       = CWP_W'(t_tt);
    cansave   = CWP_W'(t_tt >> 3);
    gl        = 3'(t_tt + t_lvl);
    tba       = 64'h0123_4567_89AB_CDEF + 64'(t_tt << 20);
    htba      = 64'hFEDC_BA98_7654_3210 ^ 64'(t_lvl << 33);
    hyper     = 1'((t_tt >> 1) ^ t_lvl);
  endtask

  function automatic logic [11:0] exp_pst(input int t_tt, input int t_lvl);
    logic [11:0] p;
    p = 12'h014;
    if (t_tt == 'h60) p[11] = 1'b1;
    else if (t_tt == 'h08 || t_tt == 'h30 || (t_tt >= 'h64 && t_tt <= 'h6F)) p[10] = 1'b1;
    else p[0] = 1'b1;
    if (t_lvl == MAXTL - 1) p[5] = 1'b1;
    return p;
  endfunction

  function automatic int exp_cwp(input int t_tt, input int c, input int cs);
    if (t_tt == 'h24) return (c + NWIN - 1) % NWIN;
    if ((t_tt & 'h1C0) == 'h080) return (c + 2 * NWIN - cs - 2) % NWIN;
    if ((t_tt & 'h1C0) == 'h0C0) return (c + 1) % NWIN;
    return c;
  endfunction

  // one accepted trap with full output and record checks
  task automatic run_trap(input int t_lvl, input int t_tt);
    logic [63:0] e_pc, e_ts;
    int e_tl;
    @(negedge clk);
    set_inputs(t_lvl, t_tt);
    trap_req = 1'b1;
    e_tl = t_lvl + 1;
    if (hyper) e_pc = (htba & ~64'h3FFF) | (64'(t_tt) << 5);
    else e_pc = (tba & ~64'h7FFF) | ((e_tl > 1) ? 64'h4000 : 64'h0) | (64'(t_tt) << 5);
    e_ts = '0;
    e_ts[2:0]   = cwp;
    e_ts[19:8]  = pstate & 12'hF3F;
    e_ts[31:24] = asi;
    e_ts[39:32] = ccr;
    e_ts[42:40] = gl;
    @(negedge clk);
    trap_req = 1'b0;
    rd_lvl = LVL_W'(e_tl);
    chk("R10 done strobe", 64'(done), 64'd1);
    chk("R2 new level", 64'(new_tl), 64'(e_tl));
    chk("R2/R6 pstate", 64'(new_pstate), 64'(exp_pst(t_tt, t_lvl)));
    chk("R7 window", 64'(new_cwp), 64'(exp_cwp(t_tt, int'(cwp), int'(cansave))));
    chk("R5 global level", 64'(new_gl), 64'((int'(gl) + 1) % 8));
    chk(hyper ? "R8 hyper vector" : "R9 vector", new_pc, e_pc);
    chk("R10 npc", new_npc, e_pc + 64'd4);
    @(negedge clk);
    chk("R10 done one cycle", 64'(done), 64'd0);
    chk("R3/R5 saved state word", rd_tstate, e_ts);
    chk("R4 saved pc", rd_tpc, cur_pc);
    chk("R4 saved npc", rd_tnpc, cur_npc);
    chk("R4 saved type", 64'(rd_tt), 64'(t_tt));
  endtask

  initial begin
    logic [63:0] pc_hold;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset err", 64'(err), 64'd0);
    chk("R10 reset pc", new_pc, 64'd0);
    chk("R10 reset level", 64'(new_tl), 64'd0);
    rst = 1'b0;

    // R2..R10: every legal level against every trap type
    for (int lv = 0; lv < MAXTL; lv++) begin
      for (int t = 0; t < 512; t++) begin
        run_trap(lv, t);
      end
    end

    // R1: trap at the ceiling freezes state
    pc_hold = new_pc;
    @(negedge clk);
    set_inputs(MAXTL, 'h41);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    rd_lvl = LVL_W'(MAXTL);
    chk("R1 err set", 64'(err), 64'd1);
    chk("R1 no done", 64'(done), 64'd0);
    chk("R1 pc held", new_pc, pc_hold);
    chk("R1 level held", 64'(new_tl), 64'(MAXTL));
    @(negedge clk);
    chk("R1 record untouched", 64'(rd_tt), 64'd511);

    // R1: later legal request ignored while in error state
    set_inputs(0, 'h10);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    rd_lvl = LVL_W'(1);
    chk("R1 ignored done", 64'(done), 64'd0);
    chk("R1 ignored level", 64'(new_tl), 64'(MAXTL));
    chk("R1 ignored pc", new_pc, pc_hold);
    chk("R1 err sticky", 64'(err), 64'd1);
    @(negedge clk);
    chk("R1 ignored record", 64'(rd_tt), 64'd511);

    // R1/R10: reset clears, level 7 also faults
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset clears err", 64'(err), 64'd0);
    chk("R10 reset clears pc", new_pc, 64'd0);
    rst = 1'b0;
    set_inputs(7, 'h22);
    trap_req = 1'b1;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R1 level 7 fault", 64'(err), 64'd1);
    chk("R1 level 7 no done", 64'(done), 64'd0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run_trap(MAXTL - 1, 'h60);
    run_trap(0, 'h24);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule